// File: doc/BRIEF.md
# Double-Edge Nibble Link Slave

This block is the receiving end of a six-wire chip-to-chip link: four data lines, a link clock and a frame-sync line, all driven by a remote master. Each byte crosses the link in two halves. The upper nibble is valid at the rising link-clock edge and the lower nibble at the falling edge. A frame begins when frame sync goes low. Frame sync going high ends the frame and holds the slave in its idle state for as long as it stays high.

The first byte of every frame is a command byte. Its bit 0 selects the direction (1 = read, 0 = write) and bits 7:1 carry a command code. In a write frame, every later byte is handed to local logic with a one-cycle strobe. In a read frame, the slave takes bytes from local logic and drives them back nibble by nibble. The slave releases the data lines at all other times.

All link inputs are brought into the system clock domain through two-flop synchronizers, and edges are found there. The system clock must run at least four times faster than the link clock.

Top module: `nibble_link_slave`

## Requirements
- R1: After reset, `lnk_d_oe`, `cmd_valid`, `rx_valid` and `tx_take` are all 0.
- R2: The first byte after a falling edge of `lnk_fs` is the command. It is assembled from the nibble on `lnk_d_i` at the rising `lnk_clk` edge (bits 7:4) and the nibble at the falling edge (bits 3:0). The block then pulses `cmd_valid` for one cycle, with `cmd_code` = bits 7:1 and `cmd_rd` = bit 0.
- R3: In a write frame (command bit 0 = 0), each later complete byte appears on `rx_data` with a one-cycle `rx_valid` pulse, in arrival order. `rx_valid` and `cmd_valid` are never high together.
- R4: In a read frame (command bit 0 = 1), the block drives `lnk_d_o` with bits 7:4 of the current transmit byte before each rising edge and with bits 3:0 before each falling edge. `lnk_d_oe` stays 1 from the command byte until the frame ends.
- R5: In a read frame, the block samples `tx_data` at the falling edge of the command byte and at each later falling edge. After each sample it pulses `tx_take` for one cycle, so the host can present the next byte.
- R6: While `lnk_fs` is high, link clock and data activity produce no strobes. `lnk_d_oe` is 0 no later than four system cycles after `lnk_fs` goes high.
- R7: A frame that ends after a rising edge but before the matching falling edge discards the partial byte. The next frame begins again with a command byte.
- R8: `lnk_d_oe` is 0 throughout a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lnk_clk | input | 1 | Link clock from master |
| lnk_fs | input | 1 | Frame sync from master, high = idle |
| lnk_d_i | input | 4 | Link data from master |
| lnk_d_o | output | 4 | Link data to master |
| lnk_d_oe | output | 1 | Output enable for link data |
| cmd_valid | output | 1 | One-cycle strobe: command byte received |
| cmd_code | output | 7 | Command code (bits 7:1 of command byte) |
| cmd_rd | output | 1 | Direction flag (bit 0 of command byte) |
| rx_valid | output | 1 | One-cycle strobe: write data byte received |
| rx_data | output | 8 | Received write data byte |
| tx_data | input | 8 | Next byte to send in a read frame |
| tx_take | output | 1 | One-cycle strobe: `tx_data` was consumed |

## Verification
The tests use write frames with several data bytes, including all-ones and all-zeros bytes. Matching these against the scoreboard shows that nibble order and edge assignment are correct, since a swapped nibble changes 0xA5 into 0x5A. A read frame with distinct transmit bytes checks that both nibbles are driven in the right phase and that a new byte is taken once per byte. Other tests cover a frame cut off between the two edges, clock and data activity with frame sync held high, and a write frame directly after a read frame. Together these show that partial bytes are dropped, that idle activity is ignored, and that the read/write mode does not carry over from one frame to the next.

// File: rtl/nibble_link_slave.sv
module nibble_link_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lnk_clk,
  input  logic       lnk_fs,
  input  logic [3:0] lnk_d_i,
  output logic [3:0] lnk_d_o,
  output logic       lnk_d_oe,
  output logic       cmd_valid,
  output logic [6:0] cmd_code,
  output logic       cmd_rd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic [7:0] tx_data,
  output logic       tx_take
);
  logic [2:0] lc_sr;
  logic [2:0] fs_sr;
  logic [3:0] d_s1, d_s2;
  logic       active, first, half, rd;
  logic [3:0] hi;
  logic [7:0] sh;

  wire rise    = lc_sr[1] & ~lc_sr[2];
  wire fall    = ~lc_sr[1] & lc_sr[2];
  wire fs_hi   = fs_sr[1];
  wire fs_fall = ~fs_sr[1] & fs_sr[2];
  wire [7:0] byte_w = {hi, d_s2};
  wire done    = active & fall & half;
  wire load    = done & (first ? byte_w[0] : rd);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lc_sr <= '0;
      fs_sr <= '1;
      d_s1  <= '0;
      d_s2  <= '0;
    end else begin
      lc_sr <= {lc_sr[1:0], lnk_clk};
      fs_sr <= {fs_sr[1:0], lnk_fs};
      d_s1  <= lnk_d_i;
      d_s2  <= d_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active    <= 1'b0;
      first     <= 1'b0;
      half      <= 1'b0;
      rd        <= 1'b0;
      hi        <= '0;
      sh        <= '0;
      lnk_d_o   <= '0;
      lnk_d_oe  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_rd    <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      tx_take   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      rx_valid  <= 1'b0;
      tx_take   <= 1'b0;
      if (fs_hi) begin
        active   <= 1'b0;
        half     <= 1'b0;
        rd       <= 1'b0;
        lnk_d_oe <= 1'b0;
      end else if (!active) begin
        if (fs_fall) begin
          active <= 1'b1;
          first  <= 1'b1;
          half   <= 1'b0;
          rd     <= 1'b0;
        end
      end else begin
        if (rise) begin
          hi   <= d_s2;
          half <= 1'b1;
          if (lnk_d_oe) lnk_d_o <= sh[3:0];
        end
        if (done) begin
          half <= 1'b0;
          if (first) begin
            first     <= 1'b0;
            cmd_valid <= 1'b1;
            cmd_code  <= byte_w[7:1];
            cmd_rd    <= byte_w[0];
            rd        <= byte_w[0];
          end else if (!rd) begin
            rx_valid <= 1'b1;
            rx_data  <= byte_w;
          end
        end
        if (load) begin
          sh       <= tx_data;
          lnk_d_o  <= tx_data[7:4];
          lnk_d_oe <= 1'b1;
          tx_take  <= 1'b1;
        end
      end
    end
endmodule

module nibble_link_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic lnk_fs,
  input logic lnk_d_oe,
  input logic cmd_valid,
  input logic rx_valid,
  input logic tx_take
);
  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R3
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R3
  rx_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && cmd_valid));
  // R5
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
  // R6
  fs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_fs && $past(lnk_fs) && $past(lnk_fs, 2) && $past(lnk_fs, 3)) |-> !lnk_d_oe);
  // R8
  rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !lnk_d_oe);
endmodule

bind nibble_link_slave nibble_link_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lnk_fs(lnk_fs), .lnk_d_oe(lnk_d_oe),
  .cmd_valid(cmd_valid), .rx_valid(rx_valid), .tx_take(tx_take)
);

// File: tb/nibble_link_slave_bench.sv
module nibble_link_slave_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       lnk_clk = 1'b0;
  logic       lnk_fs = 1'b1;
  logic [3:0] lnk_d_i = '0;
  logic [3:0] lnk_d_o;
  logic       lnk_d_oe, cmd_valid, cmd_rd, rx_valid, tx_take;
  logic [6:0] cmd_code;
  logic [7:0] rx_data;
  logic [7:0] tx_mem [0:7];
  int         tx_idx = 0;
  wire  [7:0] tx_data = tx_mem[tx_idx & 7];

  nibble_link_slave u_nibble_link_slave (.*);

  int checks = 0, fails = 0;
  int cmd_seen = 0, rx_seen = 0, takes = 0;
  logic [7:0] exp_cmd[$];
  logic [7:0] exp_rx[$];
  logic [7:0] mon_e;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin
      cmd_seen++;
      if (exp_cmd.size() == 0) chk(0, "R2 unexpected command", {cmd_code, cmd_rd}, 0);
      else begin
        mon_e = exp_cmd.pop_front();
        chk({cmd_code, cmd_rd} == mon_e, "R2 command byte", {cmd_code, cmd_rd}, mon_e);
      end
    end
    if (rx_valid) begin
      rx_seen++;
      if (exp_rx.size() == 0) chk(0, "R3 unexpected rx byte", rx_data, 0);
      else begin
        mon_e = exp_rx.pop_front();
        chk(rx_data == mon_e, "R3 rx byte", rx_data, mon_e);
      end
    end
    if (tx_take) begin
      takes++;
      tx_idx++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    lnk_d_i = b[7:4]; cyc(4); lnk_clk = 1'b1; cyc(4);
    lnk_d_i = b[3:0]; cyc(4); lnk_clk = 1'b0; cyc(4);
  endtask

  task automatic read_check(input logic [7:0] e);
    cyc(8);
    chk(lnk_d_oe == 1'b1, "R4 oe during read", lnk_d_oe, 1);
    chk(lnk_d_o == e[7:4], "R4 high nibble", lnk_d_o, e[7:4]);
    lnk_clk = 1'b1; cyc(8);
    chk(lnk_d_o == e[3:0], "R4 low nibble", lnk_d_o, e[3:0]);
    lnk_clk = 1'b0;
  endtask

  task automatic frame_start(); lnk_fs = 1'b0; cyc(8); endtask
  task automatic frame_end();   lnk_fs = 1'b1; cyc(8); endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      chk(0, "watchdog", wd, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tx_mem[0] = 8'h3C; tx_mem[1] = 8'hE1; tx_mem[2] = 8'h7F; tx_mem[3] = 8'h00;
    tx_mem[4] = 8'h00; tx_mem[5] = 8'h00; tx_mem[6] = 8'h00; tx_mem[7] = 8'h00;
    cyc(4); rst_n = 1'b1; cyc(4);
    // R1
    chk(lnk_d_oe == 0, "R1 oe", lnk_d_oe, 0);
    chk(cmd_valid == 0 && rx_valid == 0, "R1 strobes", {cmd_valid, rx_valid}, 0);
    chk(tx_take == 0, "R1 take", tx_take, 0);

    // R2 R3 R8: write frame
    exp_cmd.push_back(8'h10); exp_rx.push_back(8'hA5); exp_rx.push_back(8'h3C);
    frame_start(); send_byte(8'h10); send_byte(8'hA5);
    chk(lnk_d_oe == 0, "R8 oe in write frame", lnk_d_oe, 0);
    send_byte(8'h3C); frame_end();
    chk(rx_seen == 2, "R3 rx count", rx_seen, 2);

    // R7: partial byte
    exp_cmd.push_back(8'h22); exp_rx.push_back(8'h5A);
    frame_start(); send_byte(8'h22); send_byte(8'h5A);
    lnk_d_i = 4'hC; cyc(4); lnk_clk = 1'b1; cyc(4);
    frame_end(); lnk_clk = 1'b0; cyc(8);
    chk(rx_seen == 3, "R7 partial discarded", rx_seen, 3);

    // R6: activity while frame sync high
    send_byte(8'h11); send_byte(8'h23); cyc(8);
    chk(cmd_seen == 2, "R6 no command while idle", cmd_seen, 2);
    chk(rx_seen == 3, "R6 no rx while idle", rx_seen, 3);

    // R4 R5: read frame
    exp_cmd.push_back(8'h4B);
    frame_start(); send_byte(8'h4B); lnk_d_i = 4'h0;
    read_check(8'h3C); read_check(8'hE1); read_check(8'h7F);
    cyc(8);
    chk(takes == 4, "R5 take count", takes, 4);
    chk(lnk_d_oe == 1, "R4 oe held in frame", lnk_d_oe, 1);
    lnk_fs = 1'b1; cyc(4);
    chk(lnk_d_oe == 0, "R6 release after frame end", lnk_d_oe, 0);
    cyc(8);

    // R3 R8: write frame after read frame
    exp_cmd.push_back(8'h80); exp_rx.push_back(8'hFF); exp_rx.push_back(8'h00);
    frame_start(); send_byte(8'h80); send_byte(8'hFF);
    chk(lnk_d_oe == 0, "R8 oe after read frame", lnk_d_oe, 0);
    send_byte(8'h00); frame_end();
    chk(takes == 4, "R5 no take in write frame", takes, 4);

    chk(exp_cmd.size() == 0, "R2 commands drained", exp_cmd.size(), 0);
    chk(exp_rx.size() == 0, "R3 rx drained", exp_rx.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule